// File: doc/BRIEF.md
# Serial Port with APB Configuration

This block is a UART that sits on an APB bus as a slave. Four small registers hold the frame settings: the clock divisor, the number of data bits, the parity mode and the number of stop bits. Each setting can be written and read back over the bus. Writing a word to the transmit address sends its low data bits on the serial output line.

A frame that arrives on the serial input is oversampled at sixteen times the bit rate. It is validated and then held. It stays there until a read of the receive address collects it. That read returns the data on PRDATA.

Receive errors do not go to a status register. A frame with a wrong parity bit, or with a low stop bit, makes the read that collects it end with PSLVERR high. Flow control is done through PREADY. The bus waits while the transmitter is still busy with an earlier frame. It also waits when a read arrives and no received frame is pending.

Top module: `apb_uart_core`

## Requirements
- R1: Byte offsets 0x00 (divisor, 16 bits), 0x04 (size code, 2 bits), 0x08 (parity code, 2 bits) and 0x0C (stop code, 1 bit) are written by APB writes and read back zero-extended. Write bits above a field's width are dropped.
- R2: After PRESETn is low, the divisor reads 27, the size code reads 3, the parity code reads 0 and the stop code reads 0. TX is high and no received frame is pending.
- R3: A write to offset 0x10 sends one frame on TX. The frame is a low start bit, then 5 + size-code data bits taken from the low bits of PWDATA and sent LSB first, then an optional parity bit, then one stop bit (stop code 0) or two stop bits (stop code 1), all high. Each bit lasts 16 × divisor clocks.
- R4: Parity code 1 is odd parity, which makes the count of ones in the data bits and the parity bit odd. Code 2 is even parity. Codes 0 and 3 send no parity bit and check none.
- R5: TX is high whenever no frame is being sent.
- R6: A write to 0x10 while a frame is in progress is held with PREADY low. It is accepted once the line is free, and that frame is then sent in full.
- R7: RX is sampled every 1/16 of a bit. A start bit is accepted only if RX is still low at the centre of the bit, so a low pulse shorter than half a bit starts no frame. A read of offset 0x14 returns the received data bits, zero-extended, on PRDATA with PREADY high.
- R8: A read of 0x14 while no received frame is pending is held with PREADY low until a frame completes.
- R9: A received frame whose stop bit is low is returned with PSLVERR high on the read that collects it.
- R10: A received frame whose parity bit is wrong is returned with PSLVERR high on the read that collects it.
- R11: The read that collects a frame clears both the pending frame and its error flag. The next frame is read with PSLVERR low, and a read that arrives before that frame has completed waits.
- R12: PSLVERR is high only on a completing read of 0x14. Accesses to the configuration offsets complete without wait states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and logic clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data |
| pready | output | 1 | Transfer completes when high |
| pslverr | output | 1 | Receive error on the collecting read |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |

## Verification
The bench goes after the frame-shape corner cases. These are the shortest frame with odd parity and two stop bits, the 7-bit even frame, and parity code 3. A transmitter that mapped the codes wrongly, or let high PWDATA bits through, would put a wrong bit on TX at a mid-bit sample.

Back-to-back transmit writes check the write stall. A design that did not stall would cut short the frame in flight or drop the second word.

On the receive side, the bench checks a collecting read that arrives before any frame. It also checks a parity error and a bad stop bit, followed by a clean frame. A design that kept its error flag would report a slave error again. One that never cleared the pending frame would return stale data without waiting.

A short low pulse ahead of a real frame catches a receiver that trusts the first falling edge. Such a receiver would present a garbage frame.

// File: rtl/apb_uart_core.sv
module apb_uart_core #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int DIV_W     = 16,
  parameter int DIV_RESET = 27
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              rxd,
  output logic              txd
);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_SIZE = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_PAR  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_STOP = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_TXD  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_RXD  = ADDR_W'(8'h14);
  localparam int FRAME_W = 12;

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_state_t;

  logic [DIV_W-1:0] div_q, tcnt;
  logic [1:0]       size_q, par_q;
  logic             stop_q;
  logic             tx_busy, rx_full, rx_err;
  logic [FRAME_W-1:0] tx_sh, tx_frame;
  logic [3:0]       tx_left, tx_tc, tx_len, nbits;
  logic [7:0]       tx_dm, rx_sh, rx_buf;
  rx_state_t        rx_st;
  logic [3:0]       rx_tc;
  logic [2:0]       rx_idx;
  logic             rx_s1, rx_s2, rx_perr, rx_ferr, rx_second, rx_done;
  logic             access, hit_tx, hit_rx, wr, rd_rx, par_on, tick;
  logic             unused_bits;

  assign unused_bits = ^pwdata[DATA_W-1:DIV_W];

  assign access = psel & penable;
  assign hit_tx = (paddr == A_TXD);
  assign hit_rx = (paddr == A_RXD);
  assign pready = (hit_tx && pwrite)  ? !tx_busy :
                  (hit_rx && !pwrite) ? rx_full  : 1'b1;
  assign wr      = access & pwrite & pready;
  assign rd_rx   = access & !pwrite & hit_rx & pready;
  assign pslverr = rd_rx & rx_err;

  assign nbits  = 4'd5 + {2'b00, size_q};
  assign par_on = (par_q == 2'd1) || (par_q == 2'd2);

  always_comb begin
    prdata = '0;
    case (paddr)
      A_DIV:  prdata[DIV_W-1:0] = div_q;
      A_SIZE: prdata[1:0] = size_q;
      A_PAR:  prdata[1:0] = par_q;
      A_STOP: prdata[0] = stop_q;
      A_RXD:  prdata[7:0] = rx_buf;
      default: prdata = '0;
    endcase
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      div_q  <= DIV_W'(DIV_RESET);
      size_q <= 2'd3;
      par_q  <= 2'd0;
      stop_q <= 1'b0;
    end else if (wr) begin
      case (paddr)
        A_DIV:  div_q  <= pwdata[DIV_W-1:0];
        A_SIZE: size_q <= pwdata[1:0];
        A_PAR:  par_q  <= pwdata[1:0];
        A_STOP: stop_q <= pwdata[0];
        default: ;
      endcase
    end
  end

  assign tick = ({1'b0, tcnt} + (DIV_W+1)'(1)) >= {1'b0, div_q};

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) tcnt <= '0;
    else          tcnt <= tick ? '0 : tcnt + 1'b1;
  end

  always_comb begin
    tx_dm    = pwdata[7:0] & (8'hFF >> (2'd3 - size_q));
    tx_frame = '1;
    tx_frame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < int'(nbits)) tx_frame[i+1] = tx_dm[i];
    if (par_on) tx_frame[nbits + 4'd1] = (^tx_dm) ^ (par_q == 2'd1);
    tx_len = 4'd2 + nbits + {3'b000, par_on} + {3'b000, stop_q};
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_left <= '0;
      tx_tc   <= '0;
    end else if (wr && hit_tx) begin
      tx_busy <= 1'b1;
      tx_sh   <= tx_frame;
      tx_left <= tx_len;
      tx_tc   <= '0;
    end else if (tx_busy && tick) begin
      tx_tc <= tx_tc + 1'b1;
      if (tx_tc == 4'd15) begin
        tx_sh   <= {1'b1, tx_sh[FRAME_W-1:1]};
        tx_left <= tx_left - 1'b1;
        if (tx_left == 4'd1) tx_busy <= 1'b0;
      end
    end
  end

  assign txd = tx_busy ? tx_sh[0] : 1'b1;

  assign rx_done = tick && (rx_st == RX_STOP) && (rx_tc == 4'd15) && !(stop_q && !rx_second);

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      rx_s1 <= 1'b1; rx_s2 <= 1'b1;
      rx_st <= RX_IDLE; rx_tc <= '0; rx_idx <= '0; rx_sh <= '0;
      rx_perr <= 1'b0; rx_ferr <= 1'b0; rx_second <= 1'b0;
      rx_buf <= '0; rx_full <= 1'b0; rx_err <= 1'b0;
    end else begin
      rx_s1 <= rxd;
      rx_s2 <= rx_s1;
      if (rd_rx) begin
        rx_full <= 1'b0;
        rx_err  <= 1'b0;
      end
      if (tick) begin
        case (rx_st)
          RX_IDLE:
            if (!rx_s2) begin
              rx_st <= RX_START;
              rx_tc <= '0;
            end
          RX_START: begin
            rx_tc <= rx_tc + 1'b1;
            if (rx_tc == 4'd7) begin
              if (!rx_s2) begin
                rx_st <= RX_DATA; rx_tc <= '0; rx_idx <= '0; rx_sh <= '0;
                rx_perr <= 1'b0; rx_ferr <= 1'b0; rx_second <= 1'b0;
              end else rx_st <= RX_IDLE;
            end
          end
          RX_DATA: begin
            rx_tc <= rx_tc + 1'b1;
            if (rx_tc == 4'd15) begin
              rx_sh[rx_idx] <= rx_s2;
              rx_idx <= rx_idx + 1'b1;
              if ({1'b0, rx_idx} == nbits - 4'd1) rx_st <= par_on ? RX_PAR : RX_STOP;
            end
          end
          RX_PAR: begin
            rx_tc <= rx_tc + 1'b1;
            if (rx_tc == 4'd15) begin
              rx_perr <= ((^rx_sh) ^ rx_s2) != (par_q == 2'd1);
              rx_st   <= RX_STOP;
            end
          end
          RX_STOP: begin
            rx_tc <= rx_tc + 1'b1;
            if (rx_tc == 4'd15) begin
              if (stop_q && !rx_second) begin
                rx_second <= 1'b1;
                if (!rx_s2) rx_ferr <= 1'b1;
              end else begin
                rx_st   <= RX_IDLE;
                rx_buf  <= rx_sh;
                rx_full <= 1'b1;
                rx_err  <= rx_perr | rx_ferr | !rx_s2;
              end
            end
          end
          default: rx_st <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/apb_uart_sva.sv
module apb_uart_sva #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              pclk,
  input logic              presetn,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] prdata,
  input logic              pready,
  input logic              pslverr,
  input logic              txd,
  input logic              tx_busy,
  input logic              rx_full,
  input logic              rx_err,
  input logic              rx_done
);
  localparam logic [ADDR_W-1:0] TXA = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] RXA = ADDR_W'(8'h14);

  logic acc, rx_fire;
  assign acc     = psel && penable;
  assign rx_fire = acc && !pwrite && (paddr == RXA) && pready;

  AST_TX_IDLE_HIGH: assert property (@(posedge pclk) disable iff (!presetn)
    !tx_busy |-> txd); // R5
  AST_TX_START_LOW: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(tx_busy) |-> !txd); // R3
  AST_TX_ACCEPT: assert property (@(posedge pclk) disable iff (!presetn)
    (acc && pwrite && paddr == TXA && pready) |=> tx_busy); // R6
  AST_TX_HOLD: assert property (@(posedge pclk) disable iff (!presetn)
    (acc && pwrite && paddr == TXA && tx_busy) |-> !pready); // R6
  AST_RX_WAIT: assert property (@(posedge pclk) disable iff (!presetn)
    (acc && !pwrite && paddr == RXA && !rx_full) |-> !pready); // R8
  AST_RX_DATA_KNOWN: assert property (@(posedge pclk) disable iff (!presetn)
    rx_fire |-> !$isunknown(prdata)); // R7
  AST_ERR_ONLY_RX: assert property (@(posedge pclk) disable iff (!presetn)
    pslverr |-> rx_fire); // R12
  AST_ERR_CLEARED: assert property (@(posedge pclk) disable iff (!presetn)
    (rx_fire && !rx_done) |=> (!rx_full && !rx_err)); // R11
  AST_CFG_NO_WAIT: assert property (@(posedge pclk) disable iff (!presetn)
    (acc && paddr != TXA && paddr != RXA) |-> pready); // R12
endmodule

bind apb_uart_core apb_uart_sva #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sva (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .prdata(prdata), .pready(pready), .pslverr(pslverr), .txd(txd),
  .tx_busy(tx_busy), .rx_full(rx_full), .rx_err(rx_err), .rx_done(rx_done)
);

// File: tb/apb_uart_core_tb.sv
`timescale 1ns/1ps
module apb_uart_core_tb;
  localparam int D = 4;
  localparam logic [7:0] A_DIV = 8'h00, A_SIZE = 8'h04, A_PAR = 8'h08, A_STOP = 8'h0C;
  localparam logic [7:0] A_TXD = 8'h10, A_RXD = 8'h14;

  logic pclk = 1'b0, presetn = 1'b0, psel = 1'b0, penable = 1'b0, pwrite = 1'b0, rxd = 1'b1;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, pslverr, txd;

  int errors = 0, checks = 0;
  longint cyc = 0, quiet_after = 0;
  int m_size = 3, m_par = 0, m_stop = 0;

  apb_uart_core u_dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .rxd(rxd), .txd(txd)
  );

  always #10 pclk = ~pclk;
  always @(posedge pclk) cyc <= cyc + 1;

  function automatic int nb(); return 5 + m_size; endfunction
  function automatic int pon(); return (m_par == 1 || m_par == 2) ? 1 : 0; endfunction
  function automatic int flen(); return 2 + nb() + pon() + m_stop; endfunction
  function automatic bit pbit(input logic [7:0] d);
    int ones = 0;
    for (int i = 0; i < nb(); i++) ones += d[i];
    return (m_par == 1) ? ((ones % 2) == 0) : ((ones % 2) == 1);
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge pclk)
    if (presetn && cyc > quiet_after) begin
      checks++;
      if (txd !== 1'b1) begin
        errors++;
        $display("FAIL R5 idle line: actual=%b expected=1", txd);
      end
    end

  task automatic xfer(input bit wr, input logic [7:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output bit err, output int stall);
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1; stall = 0;
    #1;
    while (!pready) begin @(negedge pclk); #1; stall++; end
    rd = prdata; err = pslverr;
    @(posedge pclk); #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    if (wr && a == A_TXD) quiet_after = cyc + flen() * 16 * D + 2 * D;
    if (wr && a == A_SIZE) m_size = int'(d[1:0]);
    if (wr && a == A_PAR)  m_par  = int'(d[1:0]);
    if (wr && a == A_STOP) m_stop = int'(d[0]);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] r; bit e; int s;
    xfer(1'b1, a, d, r, e, s);
  endtask

  task automatic cfg(input int sz, input int pr, input int st);
    wr_reg(A_SIZE, 32'(sz)); wr_reg(A_PAR, 32'(pr)); wr_reg(A_STOP, 32'(st));
  endtask

  task automatic capture_tx(input logic [7:0] d, input string req);
    while (txd) @(negedge pclk);
    repeat (8 * D) @(negedge pclk);
    chk(req, "start bit", txd, 0);
    for (int k = 0; k < nb(); k++) begin
      repeat (16 * D) @(negedge pclk);
      chk(req, $sformatf("data bit %0d", k), txd, d[k]);
    end
    if (pon() == 1) begin
      repeat (16 * D) @(negedge pclk);
      chk("R4", "parity bit", txd, pbit(d));
    end
    for (int s = 0; s <= m_stop; s++) begin
      repeat (16 * D) @(negedge pclk);
      chk(req, "stop bit", txd, 1);
    end
  endtask

  task automatic send_rx(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    @(negedge pclk); rxd = 1'b0; repeat (16 * D) @(negedge pclk);
    for (int k = 0; k < nb(); k++) begin rxd = d[k]; repeat (16 * D) @(negedge pclk); end
    if (pon() == 1) begin rxd = pbit(d) ^ bad_par; repeat (16 * D) @(negedge pclk); end
    for (int s = 0; s <= m_stop; s++) begin
      rxd = (s == 0) ? !bad_stop : 1'b1; repeat (16 * D) @(negedge pclk);
    end
    rxd = 1'b1; repeat (16 * D) @(negedge pclk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge pclk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [31:0] r; bit e; int s;
    repeat (5) @(negedge pclk);
    presetn = 1'b1;
    @(negedge pclk);
    chk("R2", "tx after reset", txd, 1);
    xfer(1'b0, A_DIV, 0, r, e, s);  chk("R2", "divisor reset", r, 27); chk("R12", "cfg wait", s, 0);
    xfer(1'b0, A_SIZE, 0, r, e, s); chk("R2", "size reset", r, 3);     chk("R12", "cfg err", e, 0);
    xfer(1'b0, A_PAR, 0, r, e, s);  chk("R2", "parity reset", r, 0);
    xfer(1'b0, A_STOP, 0, r, e, s); chk("R2", "stop reset", r, 0);

    wr_reg(A_DIV, 32'hABCD_0004);
    xfer(1'b0, A_DIV, 0, r, e, s);  chk("R1", "divisor readback", r, D);
    wr_reg(A_SIZE, 32'hFFFF_FFF1);
    xfer(1'b0, A_SIZE, 0, r, e, s); chk("R1", "size readback", r, 1);
    wr_reg(A_PAR, 32'h0000_0003);
    xfer(1'b0, A_PAR, 0, r, e, s);  chk("R1", "parity readback", r, 3);
    wr_reg(A_STOP, 32'hFFFF_FFFF);
    xfer(1'b0, A_STOP, 0, r, e, s); chk("R1", "stop readback", r, 1);

    cfg(3, 0, 0);
    wr_reg(A_TXD, 32'h0000_00A5); capture_tx(8'hA5, "R3");
    cfg(0, 1, 1);
    wr_reg(A_TXD, 32'hFFFF_FF13); capture_tx(8'h13, "R3");
    cfg(2, 2, 0);
    wr_reg(A_TXD, 32'h0000_005A); capture_tx(8'h5A, "R4");
    cfg(3, 3, 0);
    wr_reg(A_TXD, 32'h0000_0081); capture_tx(8'h81, "R4");

    cfg(3, 0, 0);
    wr_reg(A_TXD, 32'h0000_003C);
    xfer(1'b1, A_TXD, 32'h0000_00C3, r, e, s);
    chk("R6", "write held while busy", (s >= 9 * 16 * D) ? 1 : 0, 1);
    capture_tx(8'hC3, "R6");

    fork
      xfer(1'b0, A_RXD, 0, r, e, s);
      send_rx(8'h96, 1'b0, 1'b0);
    join
    chk("R7", "rx data 8N1", r, 32'h96); chk("R8", "read waits for frame", (s >= 8 * 16 * D) ? 1 : 0, 1);
    chk("R7", "rx no error", e, 0);

    cfg(1, 2, 1);
    fork
      xfer(1'b0, A_RXD, 0, r, e, s);
      send_rx(8'h2B, 1'b0, 1'b0);
    join
    chk("R7", "rx data 6E2", r, 32'h2B); chk("R7", "6E2 no error", e, 0);

    send_rx(8'h15, 1'b1, 1'b0);
    xfer(1'b0, A_RXD, 0, r, e, s);
    chk("R10", "parity error flagged", e, 1); chk("R10", "data kept", r, 32'h15);
    fork
      xfer(1'b0, A_RXD, 0, r, e, s);
      send_rx(8'h0A, 1'b0, 1'b0);
    join
    chk("R11", "error cleared", e, 0); chk("R11", "pending cleared", (s > 0) ? 1 : 0, 1);
    chk("R11", "next data", r, 32'h0A);

    cfg(2, 1, 0);
    send_rx(8'h41, 1'b0, 1'b1);
    xfer(1'b0, A_RXD, 0, r, e, s);
    chk("R9", "stop error flagged", e, 1); chk("R9", "data kept", r, 32'h41);

    cfg(3, 0, 0);
    @(negedge pclk); rxd = 1'b0; repeat (2 * D) @(negedge pclk); rxd = 1'b1;
    repeat (32 * D) @(negedge pclk);
    fork
      xfer(1'b0, A_RXD, 0, r, e, s);
      send_rx(8'h33, 1'b0, 1'b0);
    join
    chk("R7", "glitch ignored data", r, 32'h33); chk("R7", "glitch no error", e, 0);
    chk("R7", "glitch made no frame", (s >= 8 * 16 * D) ? 1 : 0, 1);

    repeat (4) @(negedge pclk);
    summary();
  end
endmodule